// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits between a set of peripheral interrupt lines and a processor core. It keeps three bits of state for every line: enabled, pending and active. Each cycle it looks at the lines that are both pending and enabled and picks one of them. It presents that line's number to the core together with a request flag. It also reports whether the chosen line is allowed to interrupt the handler that is currently running.

Software controls the block through a small word-wide register window.
- Enable bits and pending bits each have a set register and a clear register. Writing 1 to a bit changes that line; writing 0 leaves it alone.
- Eight priority words each hold the levels of four lines.

The core gives two handshakes. Acknowledge takes the presented line: its pending bit is cleared and its active bit is set. Exit returns from the current handler. A parameter marks each line as level-sensitive or pulse-sensitive.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all enable, pending and active bits and all priorities are zero, and `irq_req` and `irq_preempt` are low.
- R2: A write to address 0x100 sets the enable bits where the data is 1. A write to 0x180 clears the enable bits where the data is 1. Zero bits leave the state unchanged. A read of either address returns the enable bits, with line n on data bit n.
- R3: A write to 0x200 sets the pending bits where the data is 1. A write to 0x280 clears the pending bits where the data is 1. A read of either address returns the pending bits, with line n on data bit n.
- R4: Priority word k sits at address 0x400+4k. Byte j of that word belongs to line 4k+j. Only bits [7:6] of each byte are stored, and they read back in place. All other bits of the word read as zero.
- R5: A pulse line becomes pending one cycle after its input rises. It stays pending after the input falls, until it is acknowledged or cleared by software.
- R6: A level line is pending in every cycle that follows a cycle in which its input was high. This holds even after a software clear or an acknowledge in that cycle.
- R7: `irq_req` is high when at least one line is both pending and enabled. `irq_id` gives the line with the numerically lowest priority value. On a tie, the lowest line number wins.
- R8: `irq_preempt` is high when `irq_req` is high and either no line is active, or the presented line's priority value is strictly lower than the lowest priority value among the active lines.
- R9: `core_ack` while `irq_preempt` is high clears the pending bit of `irq_id` and sets its active bit. `core_ack` while `irq_preempt` is low has no effect.
- R10: `core_exit` clears the active bit of the current handler. The current handler is the active line with the lowest priority value; on a tie, the lowest line number. `core_exit` with no active line has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NIRQ | Peripheral interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | A pending, enabled line exists |
| irq_id | output | IDW | Number of the selected line |
| irq_preempt | output | 1 | Selected line may pre-empt the running handler |
| core_ack | input | 1 | Core takes the presented line |
| core_exit | input | 1 | Core returns from the current handler |

## Verification
The bench targets three kinds of corner case. The first is a tie in priority value. A design that compares with the wrong strictness would select the higher-numbered line, or would let an equal-level request pre-empt a running handler. The second is nesting. After two handlers are entered, an exit must retire the inner one. A design that cleared the outer one would raise `irq_preempt` too early. The third is sensitivity. A pulse line must hold its pending bit after the input falls. A level line must come back as pending straight after an acknowledge or a software clear. A design that confused the two would either lose events or show stale pending bits. A long random phase mixes register writes, acknowledges that are refused, and exits with nothing active, against a model that is checked on every clock.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NIRQ = 32,
  parameter int PW   = 2,
  parameter int AW   = 12,
  parameter logic [NIRQ-1:0] LEVEL_LINES = 32'h0000_FFFF,
  localparam int IDW = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_req,
  output logic [IDW-1:0]  irq_id,
  output logic            irq_preempt,
  input  logic            core_ack,
  input  logic            core_exit
);
  localparam logic [AW-1:0] A_ENS  = AW'('h100);
  localparam logic [AW-1:0] A_ENC  = AW'('h180);
  localparam logic [AW-1:0] A_PDS  = AW'('h200);
  localparam logic [AW-1:0] A_PDC  = AW'('h280);
  localparam logic [AW-1:0] A_PRI  = AW'('h400);
  localparam logic [AW-1:0] A_PEND = AW'('h400 + NIRQ);

  logic [NIRQ-1:0] en_q, pend_q, act_q, irq_q;
  logic [PW-1:0]   prio_q [NIRQ];

  logic [NIRQ-1:0] cand;
  logic            win_f, cur_f;
  logic [IDW-1:0]  win_id, cur_id;
  logic [PW-1:0]   win_p, cur_p;

  assign cand = pend_q & en_q;

  always_comb begin
    win_f = 1'b0; win_id = '0; win_p = '0;
    cur_f = 1'b0; cur_id = '0; cur_p = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (cand[i] && (!win_f || prio_q[i] <= win_p)) begin
        win_f = 1'b1; win_id = IDW'(i); win_p = prio_q[i];
      end
      if (act_q[i] && (!cur_f || prio_q[i] <= cur_p)) begin
        cur_f = 1'b1; cur_id = IDW'(i); cur_p = prio_q[i];
      end
    end
  end

  assign irq_req     = win_f;
  assign irq_id      = win_id;
  assign irq_preempt = win_f && (!cur_f || win_p < cur_p);

  logic take, leave;
  logic [NIRQ-1:0] take_m, leave_m, pend_set, pend_clr;
  assign take    = core_ack && irq_preempt;
  assign leave   = core_exit && cur_f;
  assign take_m  = take  ? (NIRQ'(1) << win_id) : '0;
  assign leave_m = leave ? (NIRQ'(1) << cur_id) : '0;

  assign pend_set = (bus_we && bus_addr == A_PDS ? bus_wdata[NIRQ-1:0] : '0)
                  | (irq_in & ~irq_q & ~LEVEL_LINES)
                  | (irq_in & LEVEL_LINES);
  assign pend_clr = (bus_we && bus_addr == A_PDC ? bus_wdata[NIRQ-1:0] : '0) | take_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; pend_q <= '0; act_q <= '0; irq_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      act_q  <= (act_q & ~leave_m) | take_m;
      if (bus_we && bus_addr == A_ENS) en_q <= en_q | bus_wdata[NIRQ-1:0];
      else if (bus_we && bus_addr == A_ENC) en_q <= en_q & ~bus_wdata[NIRQ-1:0];
    end
  end

  for (genvar g = 0; g < NIRQ; g++) begin : g_prio
    localparam logic [AW-1:0] WADDR = AW'('h400 + 4 * (g / 4));
    always_ff @(posedge clk) begin
      if (!rst_n) prio_q[g] <= '0;
      else if (bus_we && bus_addr == WADDR) prio_q[g] <= bus_wdata[8*(g%4)+7 -: PW];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_ENS || bus_addr == A_ENC) bus_rdata = 32'(en_q);
    else if (bus_addr == A_PDS || bus_addr == A_PDC) bus_rdata = 32'(pend_q);
    else if (bus_addr >= A_PRI && bus_addr < A_PEND) begin
      for (int j = 0; j < 4; j++)
        bus_rdata[8*j+7 -: PW] = prio_q[(int'(bus_addr - A_PRI) / 4) * 4 + j];
    end
  end

  assert_sel_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_q[irq_id] && pend_q[irq_id]));
  assert_preempt_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_preempt |-> irq_req);
  assert_ack_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && irq_preempt) |=> act_q[$past(irq_id)]);
  assert_exit_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_exit && act_q != '0 && !(core_ack && irq_preempt)) |=>
      $countones(act_q) == $countones($past(act_q)) - 1);
  assert_clr_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_ENC) |=> (en_q & $past(bus_wdata[NIRQ-1:0])) == '0);
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam bit [31:0] LVL = 32'h0000_FFFF;

  logic clk = 0, rst_n = 0;
  logic [31:0] irq_in = '0;
  logic bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_req, irq_preempt, core_ack = 0, core_exit = 0;
  logic [4:0] irq_id;

  int total = 0, bad = 0;
  bit finished = 0;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_id(irq_id),
    .irq_preempt(irq_preempt), .core_ack(core_ack), .core_exit(core_exit));

  always #2 clk = ~clk;

  bit [31:0] m_en, m_pend, m_act, m_prev;
  int m_prio [32];

  function automatic void m_pick(input bit [31:0] v, output bit f, output int id);
    f = 0; id = 0;
    for (int lvl = 0; lvl < 4; lvl++)
      for (int i = 0; i < 32; i++)
        if (!f && v[i] && m_prio[i] == lvl) begin f = 1; id = i; end
  endfunction

  function automatic bit m_pre();
    bit wf, cf; int w, c;
    m_pick(m_en & m_pend, wf, w);
    m_pick(m_act, cf, c);
    return wf && (!cf || m_prio[w] < m_prio[c]);
  endfunction

  function automatic bit [31:0] m_read(input bit [11:0] a);
    bit [31:0] r = 0;
    if (a == 12'h100 || a == 12'h180) r = m_en;
    else if (a == 12'h200 || a == 12'h280) r = m_pend;
    else if (a >= 12'h400 && a < 12'h420)
      for (int j = 0; j < 4; j++) r[8*j+6 +: 2] = 2'(m_prio[((a - 12'h400) / 4) * 4 + j]);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_act = 0; m_prev = 0;
      for (int i = 0; i < 32; i++) m_prio[i] = 0;
    end else begin
      bit wf, cf, acc; int w, c; bit [31:0] clr, set;
      m_pick(m_en & m_pend, wf, w);
      m_pick(m_act, cf, c);
      acc = core_ack && m_pre();
      clr = 0; set = 0;
      if (bus_we && bus_addr == 12'h280) clr = bus_wdata;
      if (acc) clr[w] = 1;
      if (bus_we && bus_addr == 12'h200) set = bus_wdata;
      set |= (irq_in & ~m_prev & ~LVL) | (irq_in & LVL);
      m_pend = (m_pend & ~clr) | set;
      if (core_exit && cf) m_act[c] = 0;
      if (acc) m_act[w] = 1;
      if (bus_we && bus_addr == 12'h100) m_en |= bus_wdata;
      if (bus_we && bus_addr == 12'h180) m_en &= ~bus_wdata;
      if (bus_we && bus_addr >= 12'h400 && bus_addr < 12'h420 && bus_addr[1:0] == 0)
        for (int j = 0; j < 4; j++) m_prio[((bus_addr - 12'h400) / 4) * 4 + j] = int'(bus_wdata[8*j+6 +: 2]);
      m_prev = irq_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      bit wf; int w;
      m_pick(m_en & m_pend, wf, w);
      chk("R7 req", 32'(irq_req), 32'(wf));
      if (wf) chk("R7 id", 32'(irq_id), 32'(w));
      chk("R8 preempt", 32'(irq_preempt), 32'(m_pre()));
      chk("R2/R3/R4 rdata", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input bit [11:0] a, input bit [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic rd(input string tag, input bit [11:0] a, input bit [31:0] e);
    @(negedge clk); bus_addr = a; #1; chk(tag, bus_rdata, e);
  endtask
  task automatic ack();
    @(negedge clk); core_ack = 1; @(negedge clk); core_ack = 0; #1;
  endtask
  task automatic leave();
    @(negedge clk); core_exit = 1; @(negedge clk); core_exit = 0; #1;
  endtask

  initial begin
    #(4 * 150000);
    chk("watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1 chk("R1 req", 32'(irq_req), 0);
    chk("R1 preempt", 32'(irq_preempt), 0);
    rd("R1 enable", 12'h100, 0);
    rd("R1 pending", 12'h200, 0);
    rd("R1 prio", 12'h41C, 0);

    wr(12'h100, 32'h8001_00F3);
    rd("R2 set read", 12'h100, 32'h8001_00F3);
    rd("R2 clr read", 12'h180, 32'h8001_00F3);
    wr(12'h180, 32'h3);
    rd("R2 clear", 12'h100, 32'h8001_00F0);
    wr(12'h100, 0); wr(12'h180, 0);
    rd("R2 zero write", 12'h100, 32'h8001_00F0);

    wr(12'h400, 32'hFFFF_FFFF);
    rd("R4 mask", 12'h400, 32'hC0C0_C0C0);
    wr(12'h404, 32'h4080_C000);
    rd("R4 bytes", 12'h404, 32'h4080_C000);
    wr(12'h41C, 32'h3F3F_3F3F);
    rd("R4 low bits", 12'h41C, 0);

    wr(12'h200, 32'h0010_0000);
    rd("R3 set", 12'h200, 32'h0010_0000);
    rd("R3 clr read", 12'h280, 32'h0010_0000);
    chk("R7 disabled", 32'(irq_req), 0);
    wr(12'h280, 32'h0010_0000);
    rd("R3 clear", 12'h200, 0);

    @(negedge clk) irq_in[16] = 1;
    @(negedge clk) irq_in[16] = 0;
    rd("R5 held", 12'h200, 32'h0001_0000);
    chk("R7 req", 32'(irq_req), 1);
    chk("R7 id16", 32'(irq_id), 16);

    wr(12'h200, 32'h8000_0000);
    #1 chk("R7 tie", 32'(irq_id), 16);
    wr(12'h410, 32'h0000_0040);
    #1 chk("R7 level", 32'(irq_id), 31);
    chk("R8 idle", 32'(irq_preempt), 1);

    ack();
    rd("R9 pend cleared", 12'h200, 32'h0001_0000);
    chk("R8 not lower", 32'(irq_preempt), 0);
    ack();
    rd("R9 ignored", 12'h200, 32'h0001_0000);

    leave();
    chk("R10 exit", 32'(irq_preempt), 1);
    ack();
    chk("R9 taken", 32'(irq_req), 0);
    wr(12'h200, 32'h0000_0080);
    #1 chk("R8 tie", 32'(irq_preempt), 0);
    wr(12'h200, 32'h0000_0010);
    #1 chk("R7 id4", 32'(irq_id), 4);
    chk("R8 nest", 32'(irq_preempt), 1);
    ack();
    chk("R7 id7", 32'(irq_id), 7);
    leave();
    chk("R10 inner", 32'(irq_preempt), 0);
    leave();
    chk("R10 outer", 32'(irq_preempt), 1);
    ack(); leave();
    leave();
    chk("R10 empty", 32'(irq_req), 0);

    @(negedge clk) irq_in[5] = 1;
    rd("R6 level", 12'h200, 32'h0000_0020);
    wr(12'h280, 32'h20);
    rd("R6 sw clear", 12'h200, 32'h0000_0020);
    ack();
    rd("R6 after ack", 12'h200, 32'h0000_0020);
    irq_in[5] = 0;
    wr(12'h280, 32'h20);
    rd("R6 dropped", 12'h200, 0);
    leave();

    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      irq_in = $urandom & $urandom & $urandom;
      core_ack = ($urandom % 4) == 0;
      core_exit = ($urandom % 6) == 0;
      bus_we = ($urandom % 3) == 0;
      case ($urandom % 12)
        0: bus_addr = 12'h100;
        1: bus_addr = 12'h180;
        2: bus_addr = 12'h200;
        3: bus_addr = 12'h280;
        11: bus_addr = 12'h300;
        default: bus_addr = 12'(12'h400 + 4 * ($urandom % 8));
      endcase
      bus_wdata = (bus_addr == 12'h200) ? ($urandom & $urandom & $urandom) : $urandom;
    end
    @(negedge clk);
    bus_we = 0; core_ack = 0; core_exit = 0;
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule